// File: doc/BRIEF.md
# Double to half precision converter

This block converts a 64-bit IEEE-754 double-precision word into a 16-bit half-precision word. It rounds to nearest, and an exact tie goes to the even result. Normal values are rebiased and rounded. Values below the half normal range underflow gradually into half subnormals or zero. Values above the largest half exponent become infinity. An infinity stays infinity, and any NaN becomes the canonical quiet NaN. The sign is always kept.

All of the arithmetic is one combinational path that ends in a single output register. The sample is marked by a valid strobe, and its result appears on the output with its own valid strobe exactly one clock later. There is no back-pressure, so a new sample can be accepted on every cycle.

Top module: `d2h_convert`

## Requirements
- R1: `out_valid` equals `in_valid` one clock later. `out_data` is loaded only on a cycle where `in_valid` is high, and it keeps its value on every other cycle.
- R2: While `rst_n` is low at a clock edge, `out_valid` and `out_data` are cleared to zero.
- R3: Output bit 15 equals input bit 63 for every class of result: zero, subnormal, normal, infinity and NaN.
- R4: Input fields are sign in bit 63, an 11-bit exponent in bits 62:52 with bias 1023, and a 52-bit fraction in bits 51:0. Output fields are sign in bit 15, a 5-bit exponent in bits 14:10 with bias 15, and a 10-bit fraction in bits 9:0. A value in the half normal range is rounded to nearest, and an exact tie goes to the result whose fraction LSB is 0. For example, 1.0 gives 0x3C00, 1+2^-11 gives 0x3C00, 1+3*2^-11 gives 0x3C02, and 1+2^-11+2^-52 gives 0x3C01.
- R5: A carry out of the fraction during rounding increments the exponent field. The largest subnormal plus half an ulp rounds to 0x0400. An input of 65520 rounds to 0x7C00, while the largest double below 65520 gives 0x7BFF.
- R6: A finite input whose exponent field is above 1038 (an unbiased exponent above 15) gives magnitude 0x7C00.
- R7: An input whose unbiased exponent is below -14 is denormalised to a half subnormal, or to zero, with the same round-to-nearest-even rule. For example, 2^-24 gives 0x0001, 2^-25 gives 0x0000, 1.5*2^-24 gives 0x0002, and 3.5*2^-24 gives 0x0004.
- R8: Any input with exponent field 0 (a zero or a double subnormal) gives a signed zero.
- R9: An input with exponent field 0x7FF and a zero fraction gives magnitude 0x7C00.
- R10: An input with exponent field 0x7FF and any nonzero fraction, including a payload only in bits 40:0, gives magnitude 0x7E00. No other magnitude with exponent field 0x1F is ever produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks `in_data` as a sample to convert |
| in_data | input | 64 | Double-precision source word |
| out_valid | output | 1 | Marks `out_data` as a converted result |
| out_data | output | 16 | Half-precision result |

## Verification
The exponent field is swept across the whole band where the result changes class, from far below the smallest subnormal up to overflow. The sweep also takes in the zero and all-ones fields. At each exponent, sixteen fraction patterns toggle the kept LSB, the guard bit, a lone sticky bit at bit 0 and a high run of ones, with both signs. This separates ties that round to even from ties that round to odd, and it shows whether sticky bits deep in the discarded 41 bits are captured. Directed values cover the borders between classes: the largest subnormal rounding into the smallest normal, 65520 against the largest double below it, and NaNs whose payload sits only in the lowest bits. Random words, half of them with the exponent confined to the interesting band, are compared with an integer rounding model that scales the full 53-bit significand to the target quantum.

// File: rtl/d2h_pkg.sv
package d2h_pkg;

   // Result class chosen from the rebiased exponent and the source field
   typedef enum logic [1:0] {
      KIND_NORMAL  = 2'd0,
      KIND_TINY    = 2'd1,
      KIND_HUGE    = 2'd2,
      KIND_SPECIAL = 2'd3
   } d2h_kind_e;

   // Clamp a signed shift request into 0..hi
   function automatic int clamp_shift(input int raw, input int hi);
      if (raw < 0)
         return 0;
      else if (raw > hi)
         return hi;
      else
         return raw;
   endfunction

endpackage

// File: rtl/d2h_unpack.sv
module d2h_unpack
   import d2h_pkg::*;
#(
   parameter int SRC_EXP_W = 11,
   parameter int SRC_MAN_W = 52,
   parameter int DST_EXP_W = 5,
   parameter int DST_MAN_W = 10
) (
   input  logic [SRC_EXP_W+SRC_MAN_W:0] src,
   output logic                         sign,
   output logic signed [31:0]           exp_rb,
   output logic [DST_MAN_W+1:0]         sig,
   output d2h_kind_e                    kind
);
   localparam int SIG_W    = DST_MAN_W + 2;
   localparam int KEEP     = DST_MAN_W + 1;
   localparam int DROP     = SRC_MAN_W - KEEP;
   localparam int SRC_BIAS = (1 << (SRC_EXP_W - 1)) - 1;
   localparam int DST_BIAS = (1 << (DST_EXP_W - 1)) - 1;
   localparam int REBIAS   = DST_BIAS - SRC_BIAS;
   localparam int MAX_E    = (1 << DST_EXP_W) - 2;

   logic [SRC_EXP_W-1:0] exp_f;
   logic [SRC_MAN_W-1:0] man_f;

   assign {sign, exp_f, man_f} = src;

   always_comb begin
      exp_rb = $signed({{(32-SRC_EXP_W){1'b0}}, exp_f}) + REBIAS;
      // kept fraction bits plus guard, then everything below folded into one sticky
      sig    = {man_f[SRC_MAN_W-1 -: KEEP], |man_f[DROP-1:0]};
      if (&exp_f)
         kind = KIND_SPECIAL;
      else if (exp_rb > MAX_E)
         kind = KIND_HUGE;
      else if (exp_rb < 1)
         kind = KIND_TINY;
      else
         kind = KIND_NORMAL;
   end

   if (SIG_W != KEEP + 1) begin : g_bad_sig
      $error("d2h_unpack: significand width mismatch");
   end

endmodule

// File: rtl/d2h_denorm.sv
module d2h_denorm
   import d2h_pkg::*;
#(
   parameter int DST_MAN_W = 10
) (
   input  logic signed [31:0]   exp_rb,
   input  logic [DST_MAN_W+1:0] sig,
   output logic [DST_MAN_W+2:0] den
);
   localparam int SIG_W  = DST_MAN_W + 2;
   localparam int WIDE_W = SIG_W + 1;
   localparam int SH_MAX = DST_MAN_W + 3;
   localparam int SH_W   = $clog2(SH_MAX + 1);

   logic [SH_W-1:0]             amt;
   logic [SH_W:0][WIDE_W-1:0]   stg;
   logic [SH_W:0]               lost;

   always_comb begin
      amt = SH_W'(clamp_shift(32'sd1 - exp_rb, SH_MAX));
   end

   // hidden one restored above the significand
   assign stg[0]  = {1'b1, sig};
   assign lost[0] = 1'b0;

   // log-depth right shifter, each stage folds the bits it drops into sticky
   for (genvar k = 0; k < SH_W; k++) begin : g_stage
      localparam int STEP = 1 << k;
      if (STEP < WIDE_W) begin : g_part
         assign stg[k+1]  = amt[k] ? (stg[k] >> STEP) : stg[k];
         assign lost[k+1] = lost[k] | (amt[k] & (|stg[k][STEP-1:0]));
      end else begin : g_full
         assign stg[k+1]  = amt[k] ? '0 : stg[k];
         assign lost[k+1] = lost[k] | (amt[k] & (|stg[k]));
      end
   end

   assign den = stg[SH_W] | {{(WIDE_W-1){1'b0}}, lost[SH_W]};

endmodule

// File: rtl/d2h_round.sv
module d2h_round #(
   parameter int DST_EXP_W = 5,
   parameter int DST_MAN_W = 10
) (
   input  logic [DST_EXP_W+DST_MAN_W+1:0] cand,
   output logic [DST_EXP_W+DST_MAN_W-1:0] mag
);
   localparam int CAND_W = DST_EXP_W + DST_MAN_W + 2;
   localparam int MAG_W  = DST_EXP_W + DST_MAN_W;

   logic [2:0] tail;
   logic       bump;

   // tail = {kept lsb, guard, sticky}; increment on guard with sticky or odd lsb
   always_comb begin
      tail = cand[2:0];
      bump = (tail == 3'd3) || (tail > 3'd5);
      mag  = cand[CAND_W-1:2] + MAG_W'(bump);
   end

endmodule

// File: rtl/d2h_convert.sv
module d2h_convert
   import d2h_pkg::*;
#(
   parameter int SRC_EXP_W = 11,
   parameter int SRC_MAN_W = 52,
   parameter int DST_EXP_W = 5,
   parameter int DST_MAN_W = 10
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         in_valid,
   input  logic [SRC_EXP_W+SRC_MAN_W:0] in_data,
   output logic                         out_valid,
   output logic [DST_EXP_W+DST_MAN_W:0] out_data
);
   localparam int SIG_W  = DST_MAN_W + 2;
   localparam int WIDE_W = SIG_W + 1;
   localparam int CAND_W = DST_EXP_W + DST_MAN_W + 2;
   localparam int MAG_W  = DST_EXP_W + DST_MAN_W;
   localparam logic [MAG_W-1:0] INF_MAG  = MAG_W'(((1 << DST_EXP_W) - 1) << DST_MAN_W);
   localparam logic [MAG_W-1:0] QNAN_MAG = INF_MAG | MAG_W'(1 << (DST_MAN_W - 1));

   if (SRC_MAN_W < DST_MAN_W + 2) begin : g_chk_man
      $error("d2h_convert: source fraction too narrow");
   end
   if (SRC_EXP_W <= DST_EXP_W) begin : g_chk_exp
      $error("d2h_convert: source exponent must be wider");
   end
   if (SRC_EXP_W > 24 || DST_EXP_W < 2) begin : g_chk_range
      $error("d2h_convert: exponent widths outside supported range");
   end
   if (DST_MAN_W < 2) begin : g_chk_dman
      $error("d2h_convert: destination fraction too narrow");
   end

   logic                  sign;
   logic signed [31:0]    exp_rb;
   logic [SIG_W-1:0]      sig;
   d2h_kind_e             kind;
   logic [WIDE_W-1:0]     den;
   logic [CAND_W-1:0]     cand;
   logic [MAG_W-1:0]      rounded;
   logic [MAG_W-1:0]      mag_sel;

   d2h_unpack #(
      .SRC_EXP_W (SRC_EXP_W),
      .SRC_MAN_W (SRC_MAN_W),
      .DST_EXP_W (DST_EXP_W),
      .DST_MAN_W (DST_MAN_W)
   ) i_unpack (
      .src    (in_data),
      .sign   (sign),
      .exp_rb (exp_rb),
      .sig    (sig),
      .kind   (kind)
   );

   d2h_denorm #(
      .DST_MAN_W (DST_MAN_W)
   ) i_denorm (
      .exp_rb (exp_rb),
      .sig    (sig),
      .den    (den)
   );

   // normal candidate is the rebiased exponent placed above the 12-bit significand
   always_comb begin
      if (kind == KIND_TINY)
         cand = CAND_W'(den);
      else
         cand = {exp_rb[DST_EXP_W-1:0], sig};
   end

   d2h_round #(
      .DST_EXP_W (DST_EXP_W),
      .DST_MAN_W (DST_MAN_W)
   ) i_round (
      .cand (cand),
      .mag  (rounded)
   );

   always_comb begin
      unique case (kind)
         KIND_SPECIAL: mag_sel = (sig != '0) ? QNAN_MAG : INF_MAG;
         KIND_HUGE:    mag_sel = INF_MAG;
         default:      mag_sel = rounded;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid)
            out_data <= {sign, mag_sel};
      end
   end

endmodule

// File: rtl/d2h_convert_chk.sv
module d2h_convert_chk #(
   parameter int SRC_EXP_W = 11,
   parameter int SRC_MAN_W = 52,
   parameter int DST_EXP_W = 5,
   parameter int DST_MAN_W = 10
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         in_valid,
   input logic [SRC_EXP_W+SRC_MAN_W:0] in_data,
   input logic                         out_valid,
   input logic [DST_EXP_W+DST_MAN_W:0] out_data
);
   localparam int SRC_W    = SRC_EXP_W + SRC_MAN_W + 1;
   localparam int MAG_W    = DST_EXP_W + DST_MAN_W;
   localparam int SRC_BIAS = (1 << (SRC_EXP_W - 1)) - 1;
   localparam int DST_BIAS = (1 << (DST_EXP_W - 1)) - 1;
   localparam int MAX_E    = (1 << DST_EXP_W) - 2;
   localparam int OVF_FLD  = SRC_BIAS + MAX_E - DST_BIAS;
   localparam logic [MAG_W-1:0] INF_MAG  = MAG_W'(((1 << DST_EXP_W) - 1) << DST_MAN_W);
   localparam logic [MAG_W-1:0] QNAN_MAG = INF_MAG | MAG_W'(1 << (DST_MAN_W - 1));

   logic armed = 1'b0;
   always_ff @(posedge clk) armed <= rst_n;

   logic [SRC_EXP_W-1:0] src_exp;
   logic [SRC_MAN_W-1:0] src_man;
   logic                 take_inf, take_nan, take_zero, take_big;

   assign src_exp   = in_data[SRC_W-2 -: SRC_EXP_W];
   assign src_man   = in_data[SRC_MAN_W-1:0];
   assign take_inf  = in_valid && (&src_exp) && (src_man == '0);
   assign take_nan  = in_valid && (&src_exp) && (src_man != '0);
   assign take_zero = in_valid && (src_exp == '0);
   assign take_big  = in_valid && !(&src_exp) &&
                      ($signed({{(32-SRC_EXP_W){1'b0}}, src_exp}) > OVF_FLD);

   // R1
   valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (out_valid == $past(in_valid)));

   // R1
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$past(in_valid)) |-> $stable(out_data));

   // R3
   sign_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(in_valid)) |-> (out_data[MAG_W] == $past(in_data[SRC_W-1])));

   // R6
   overflow_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(take_big)) |-> (out_data[MAG_W-1:0] == INF_MAG));

   // R8
   zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(take_zero)) |-> (out_data[MAG_W-1:0] == '0));

   // R9
   inf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(take_inf)) |-> (out_data[MAG_W-1:0] == INF_MAG));

   // R10
   nan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(take_nan)) |-> (out_data[MAG_W-1:0] == QNAN_MAG));

   // R10
   special_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (&out_data[MAG_W-1:DST_MAN_W])) |->
      (out_data[MAG_W-1:0] == INF_MAG || out_data[MAG_W-1:0] == QNAN_MAG));

endmodule

bind d2h_convert d2h_convert_chk #(
   .SRC_EXP_W (SRC_EXP_W),
   .SRC_MAN_W (SRC_MAN_W),
   .DST_EXP_W (DST_EXP_W),
   .DST_MAN_W (DST_MAN_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_data   (in_data),
   .out_valid (out_valid),
   .out_data  (out_data)
);

// File: tb/test_d2h_convert.sv
`timescale 1ns/1ps
module test_d2h_convert;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] in_data = '0;
   logic        out_valid;
   logic [15:0] out_data;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   d2h_convert i_d2h_convert (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   // Integer model: scale the 53-bit significand to the half quantum and round
   function automatic logic [15:0] ref_half(input logic [63:0] x);
      int          ef;
      logic [51:0] mf;
      longint      ue, sh, mag, lo;
      logic [63:0] sv, q, rem, halfq;
      ef = int'(x[62:52]);
      mf = x[51:0];
      if (ef == 2047) begin
         mag = (mf == '0) ? 64'h7C00 : 64'h7E00;
      end else if (ef == 0) begin
         mag = 0;
      end else begin
         ue = longint'(ef) - 1023;
         sv = {11'b0, 1'b1, mf};
         lo = (ue < -14) ? -14 : ue;
         sh = lo - ue + 42;
         if (sh > 60) sh = 60;
         q     = sv >> sh;
         rem   = sv & ((64'd1 << sh) - 64'd1);
         halfq = 64'd1 << (sh - 1);
         if (rem > halfq || (rem == halfq && q[0])) q = q + 64'd1;
         mag = longint'(q) + ((ue >= -14) ? ((ue + 14) <<< 10) : 0);
         if (mag >= 64'h7C00) mag = 64'h7C00;
      end
      return {x[63], mag[14:0]};
   endfunction

   function automatic string tag_of(input logic [63:0] x);
      int ef;
      ef = int'(x[62:52]);
      if (ef == 2047) return (x[51:0] == '0) ? "R9" : "R10";
      if (ef == 0)    return "R8";
      if (ef > 1038)  return "R6";
      if (ef < 1009)  return "R7";
      return "R4";
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic apply_exp(input string tag, input logic [63:0] x, input logic [15:0] exp);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = x;
      @(negedge clk);
      chk(tag, {15'b0, out_valid, out_data}, {15'b0, 1'b1, exp});
      in_valid = 1'b0;
   endtask

   task automatic apply_ref(input logic [63:0] x);
      apply_exp(tag_of(x), x, ref_half(x));
   endtask

   initial begin
      // R2: reset clears the output while a sample is offered
      in_valid = 1'b1;
      in_data  = 64'h3FF0000000000000;
      repeat (3) @(negedge clk);
      chk("R2 valid", {31'b0, out_valid}, 32'd0);
      chk("R2 data", {16'b0, out_data}, 32'd0);
      in_valid = 1'b0;
      rst_n    = 1'b1;
      @(negedge clk);
      chk("R1 idle after reset", {31'b0, out_valid}, 32'd0);

      // R4 normals and ties
      apply_exp("R4 one", 64'h3FF0000000000000, 16'h3C00);
      apply_exp("R4 tie even", 64'h3FF0020000000000, 16'h3C00);
      apply_exp("R4 tie odd", 64'h3FF0060000000000, 16'h3C02);
      apply_exp("R4 above tie", 64'h3FF0020000000001, 16'h3C01);
      apply_exp("R4 max normal", 64'h40EFFC0000000000, 16'h7BFF);
      apply_exp("R4 min normal", 64'h3F10000000000000, 16'h0400);
      // R3 sign
      apply_exp("R3 neg two", 64'hC000000000000000, 16'hC000);
      apply_exp("R3 neg zero", 64'h8000000000000000, 16'h8000);
      // R5 carries
      apply_exp("R5 round to inf", 64'h40EFFE0000000000, 16'h7C00);
      apply_exp("R5 below threshold", 64'h40EFFDFFFFFFFFFF, 16'h7BFF);
      apply_exp("R5 sub to normal", 64'h3F0FFE0000000000, 16'h0400);
      // R6 overflow
      apply_exp("R6 65536", 64'h40F0000000000000, 16'h7C00);
      apply_exp("R6 dbl max neg", 64'hFFEFFFFFFFFFFFFF, 16'hFC00);
      // R7 subnormals
      apply_exp("R7 min sub", 64'h3E70000000000000, 16'h0001);
      apply_exp("R7 half min sub", 64'h3E60000000000000, 16'h0000);
      apply_exp("R7 above half min sub", 64'h3E60000000000001, 16'h0001);
      apply_exp("R7 tie 1.5", 64'h3E78000000000000, 16'h0002);
      apply_exp("R7 tie 2.5", 64'h3E84000000000000, 16'h0002);
      apply_exp("R7 tie 3.5", 64'h3E8C000000000000, 16'h0004);
      // R8 zeros and double subnormals
      apply_exp("R8 pos zero", 64'h0000000000000000, 16'h0000);
      apply_exp("R8 tiny sub", 64'h0000000000000001, 16'h0000);
      apply_exp("R8 neg big sub", 64'h800FFFFFFFFFFFFF, 16'h8000);
      // R9 / R10 specials
      apply_exp("R9 pos inf", 64'h7FF0000000000000, 16'h7C00);
      apply_exp("R9 neg inf", 64'hFFF0000000000000, 16'hFC00);
      apply_exp("R10 low payload", 64'h7FF0000000000001, 16'h7E00);
      apply_exp("R10 neg qnan", 64'hFFF8000000000000, 16'hFE00);

      // R1: output held while idle
      apply_exp("R1 load", 64'h3FF0000000000000, 16'h3C00);
      in_data = 64'hC000000000000000;
      @(negedge clk);
      chk("R1 idle valid", {31'b0, out_valid}, 32'd0);
      chk("R1 idle hold", {16'b0, out_data}, 32'h3C00);
      @(negedge clk);
      chk("R1 idle hold 2", {16'b0, out_data}, 32'h3C00);

      // Sweep of exponent band and fraction patterns, both signs
      for (int e = 993; e <= 1049; e++) begin
         for (int p = 0; p < 16; p++) begin
            for (int s = 0; s < 2; s++) begin
               logic [51:0] m;
               logic [10:0] ef;
               m = '0;
               if (p[0]) m[42] = 1'b1;
               if (p[1]) m[41] = 1'b1;
               if (p[2]) m[0] = 1'b1;
               if (p[3]) m[51:43] = 9'h1FF;
               ef = (e == 993) ? 11'd0 : (e == 994) ? 11'd2047 :
                    (e == 995) ? 11'd1 : 11'(e);
               apply_ref({s[0], ef, m});
            end
         end
      end

      // Random words, half of them confined to the interesting band
      for (int i = 0; i < 4000; i++) begin
         logic [63:0] x;
         x = {$urandom, $urandom};
         if (i % 2 == 0) x[62:52] = 11'(990 + ($urandom % 60));
         apply_ref(x);
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog R1: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule